// File: doc/BRIEF.md
# Interrupt Level Gate and Vector Generator

This block sits beside a processor core and decides, each cycle, whether a pending event may interrupt the program. Maskable sources present a 5-bit level and a vector number. A source is taken only when its level is numerically below the current interrupt level mask held in the block. Among the eligible sources, the one with the smallest level wins. Taking a maskable source raises the mask to that level, so only more urgent sources can nest on top of it.

A separate exempt input carries the traps that ignore the mask: undefined instruction, missing coprocessor, coprocessor error and the software interrupt instruction. Taking one of these leaves the mask unchanged. Two further inputs request the mode and reset vectors. Those two addresses are fixed and do not move with the table base.

Every other vector address is formed from a writable table base register. The table has 4-byte entries and counts downward from the top of a 1 KB window above that base. The block also owns the software write path to the mask. It refuses a write that would drop the mask from the interrupt range (16 and up) into the system range (below 16).

Top module: `irq_gate_top`

## Requirements
- R1: After reset the mask reads 15, the table base reads 0x000FFC00, and take_o is low.
- R2: A maskable source is eligible only when its valid bit is set and its level is numerically less than the mask. A source whose level is equal to or above the mask produces no take.
- R3: A maskable source at level 31 is never taken, whatever the mask value.
- R4: When several maskable sources are eligible, the lowest level wins. A tie on level goes to the lowest vector number.
- R5: A request sampled on one rising edge drives take_o high for exactly the cycle that follows. The outputs in that cycle are take_kind_o, vec_num_o and vec_addr_o. For a maskable take, take_level_o carries the accepted level and the mask is loaded with it on that same edge.
- R6: For a maskable or exempt take, vec_addr_o equals table base + (0x3FC − 4 × vector number), with bits 1:0 forced to 00.
- R7: The exempt input is taken whatever the mask value, and the mask is left unchanged. take_kind_o encodes the source class: 0 maskable, 1 exempt, 2 mode, 3 reset.
- R8: A mode request gives vec_addr_o 0x000FFFF8 with vector number 1. A reset-vector request gives 0x000FFFFC with vector number 0. Neither address depends on the table base. Priority runs reset over mode over exempt over maskable.
- R9: A mask write is ignored, and the mask keeps its old value, when the mask is 16 or more and the written value is below 16.
- R10: Any other mask write takes effect on the next edge. A maskable take on the same edge has precedence over the write.
- R11: A table base write takes effect on the next edge and is used by every later maskable or exempt vector address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_valid_i | input | N_SRC | Per-source pending flag |
| src_level_i | input | N_SRC*5 | Per-source level, source i in bits [5i+4:5i] |
| src_vec_i | input | N_SRC*8 | Per-source vector number, source i in bits [8i+7:8i] |
| exc_valid_i | input | 1 | Mask-exempt trap request |
| exc_vec_i | input | 8 | Vector number of the exempt trap |
| mode_req_i | input | 1 | Request for the fixed mode vector |
| rstv_req_i | input | 1 | Request for the fixed reset vector |
| ilm_we_i | input | 1 | Mask write strobe |
| ilm_wdata_i | input | 5 | Mask write value |
| tbr_we_i | input | 1 | Table base write strobe |
| tbr_wdata_i | input | 32 | Table base write value |
| take_o | output | 1 | One-cycle accept strobe |
| take_kind_o | output | 2 | Class of the accepted event |
| take_level_o | output | 5 | Accepted level (maskable), else 0 |
| vec_num_o | output | 8 | Accepted vector number |
| vec_addr_o | output | 32 | Vector fetch address |
| ilm_o | output | 5 | Current interrupt level mask |
| tbr_o | output | 32 | Current table base |

## Verification
The maskable path is tested with one source at a time to exercise the strict less-than gate. A source at exactly the mask level tells a less-or-equal comparison apart from a strict one, and a level-31 source shows that the disabled level is never taken. Four sources with a shared winning level but different vector numbers show that the tie-break uses the vector number rather than the source index. Exempt, mode and reset requests are combined with pending maskable sources and with an unaligned table base. This shows both the priority order and that only the floating vectors follow the base. Mask writes are tried from either side of 16 and alongside a maskable take, which tells the clamp rule and the write-versus-accept precedence apart.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned LVL_W  = 5;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned ADDR_W = 32;

  localparam logic [LVL_W-1:0]  LVL_OFF    = 5'd31;
  localparam logic [LVL_W-1:0]  LVL_USER   = 5'd16;
  localparam logic [LVL_W-1:0]  ILM_RST    = 5'd15;
  localparam logic [ADDR_W-1:0] TBR_RST    = 32'h000F_FC00;
  localparam logic [ADDR_W-1:0] TBL_TOP    = 32'h0000_03FC;
  localparam logic [ADDR_W-1:0] MODE_ADDR  = 32'h000F_FFF8;
  localparam logic [ADDR_W-1:0] RSTV_ADDR  = 32'h000F_FFFC;
  localparam logic [VEC_W-1:0]  MODE_VNUM  = 8'd1;
  localparam logic [VEC_W-1:0]  RSTV_VNUM  = 8'd0;

  typedef enum logic [1:0] {
    KIND_MASK = 2'd0,
    KIND_EXC  = 2'd1,
    KIND_MODE = 2'd2,
    KIND_RSTV = 2'd3
  } take_kind_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_gate_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic [N_SRC-1:0]       valid_i,
  input  logic [N_SRC*LVL_W-1:0] level_i,
  input  logic [N_SRC*VEC_W-1:0] vec_i,
  input  logic [LVL_W-1:0]       ilm_i,
  output logic                   found_o,
  output logic [LVL_W-1:0]       level_o,
  output logic [VEC_W-1:0]       vec_o
);
  logic [LVL_W-1:0] lv [N_SRC];
  logic [VEC_W-1:0] vn [N_SRC];
  logic [N_SRC-1:0] elig;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign lv[i]   = level_i[i*LVL_W +: LVL_W];
    assign vn[i]   = vec_i[i*VEC_W +: VEC_W];
    assign elig[i] = valid_i[i] && (lv[i] != LVL_OFF) && (lv[i] < ilm_i);
  end

  always_comb begin
    found_o = 1'b0;
    level_o = '1;
    vec_o   = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found_o || (lv[i] < level_o) ||
                      ((lv[i] == level_o) && (vn[i] < vec_o)))) begin
        found_o = 1'b1;
        level_o = lv[i];
        vec_o   = vn[i];
      end
    end
  end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
  import irq_gate_pkg::*;
(
  input  logic [ADDR_W-1:0] tbr_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [1:0]        kind_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] vec_off;
  logic [ADDR_W-1:0] sum;

  assign vec_off = TBL_TOP - {{(ADDR_W-VEC_W-2){1'b0}}, vec_i, 2'b00};
  assign sum     = tbr_i + vec_off;

  always_comb begin
    unique case (kind_i)
      KIND_MODE: addr_o = MODE_ADDR;
      KIND_RSTV: addr_o = RSTV_ADDR;
      default:   addr_o = {sum[ADDR_W-1:2], 2'b00};
    endcase
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [LVL_W-1:0]  acc_level_i,
  input  logic              ilm_we_i,
  input  logic [LVL_W-1:0]  ilm_wdata_i,
  input  logic              tbr_we_i,
  input  logic [ADDR_W-1:0] tbr_wdata_i,
  output logic [LVL_W-1:0]  ilm_o,
  output logic [ADDR_W-1:0] tbr_o
);
  logic [LVL_W-1:0]  ilm_q;
  logic [ADDR_W-1:0] tbr_q;
  logic              wr_block;

  // program may not drop the mask from the user range into the system range
  assign wr_block = (ilm_q >= LVL_USER) && (ilm_wdata_i < LVL_USER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ilm_q <= ILM_RST;
    end else if (acc_i) begin
      ilm_q <= acc_level_i;
    end else if (ilm_we_i && !wr_block) begin
      ilm_q <= ilm_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tbr_q <= TBR_RST;
    else if (tbr_we_i) tbr_q <= tbr_wdata_i;
  end

  assign ilm_o = ilm_q;
  assign tbr_o = tbr_q;
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
  import irq_gate_pkg::*;
#(
  parameter int unsigned N_SRC = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_valid_i,
  input  logic [N_SRC*LVL_W-1:0] src_level_i,
  input  logic [N_SRC*VEC_W-1:0] src_vec_i,
  input  logic                   exc_valid_i,
  input  logic [VEC_W-1:0]       exc_vec_i,
  input  logic                   mode_req_i,
  input  logic                   rstv_req_i,
  input  logic                   ilm_we_i,
  input  logic [LVL_W-1:0]       ilm_wdata_i,
  input  logic                   tbr_we_i,
  input  logic [ADDR_W-1:0]      tbr_wdata_i,
  output logic                   take_o,
  output logic [1:0]             take_kind_o,
  output logic [LVL_W-1:0]       take_level_o,
  output logic [VEC_W-1:0]       vec_num_o,
  output logic [ADDR_W-1:0]      vec_addr_o,
  output logic [LVL_W-1:0]       ilm_o,
  output logic [ADDR_W-1:0]      tbr_o
);
  logic              pick_found;
  logic [LVL_W-1:0]  pick_level;
  logic [VEC_W-1:0]  pick_vec;
  logic              nxt_take;
  take_kind_e        nxt_kind;
  logic [LVL_W-1:0]  nxt_level;
  logic [VEC_W-1:0]  nxt_vec;
  logic [ADDR_W-1:0] nxt_addr;
  logic              acc_mask;

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .valid_i (src_valid_i),
    .level_i (src_level_i),
    .vec_i   (src_vec_i),
    .ilm_i   (ilm_o),
    .found_o (pick_found),
    .level_o (pick_level),
    .vec_o   (pick_vec)
  );

  always_comb begin
    nxt_take  = 1'b1;
    nxt_kind  = KIND_MASK;
    nxt_level = '0;
    nxt_vec   = pick_vec;
    if (rstv_req_i) begin
      nxt_kind = KIND_RSTV;
      nxt_vec  = RSTV_VNUM;
    end else if (mode_req_i) begin
      nxt_kind = KIND_MODE;
      nxt_vec  = MODE_VNUM;
    end else if (exc_valid_i) begin
      nxt_kind = KIND_EXC;
      nxt_vec  = exc_vec_i;
    end else if (pick_found) begin
      nxt_level = pick_level;
    end else begin
      nxt_take = 1'b0;
      nxt_vec  = '0;
    end
  end

  assign acc_mask = nxt_take && (nxt_kind == KIND_MASK);

  irq_vec_addr u_addr (
    .tbr_i  (tbr_o),
    .vec_i  (nxt_vec),
    .kind_i (nxt_kind),
    .addr_o (nxt_addr)
  );

  irq_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc_mask),
    .acc_level_i (pick_level),
    .ilm_we_i    (ilm_we_i),
    .ilm_wdata_i (ilm_wdata_i),
    .tbr_we_i    (tbr_we_i),
    .tbr_wdata_i (tbr_wdata_i),
    .ilm_o       (ilm_o),
    .tbr_o       (tbr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o       <= 1'b0;
      take_kind_o  <= KIND_MASK;
      take_level_o <= '0;
      vec_num_o    <= '0;
      vec_addr_o   <= '0;
    end else begin
      take_o       <= nxt_take;
      take_kind_o  <= nxt_kind;
      take_level_o <= nxt_level;
      vec_num_o    <= nxt_vec;
      vec_addr_o   <= nxt_take ? nxt_addr : '0;
    end
  end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
  import irq_gate_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ilm_we_i,
  input logic [LVL_W-1:0]  ilm_wdata_i,
  input logic              take_o,
  input logic [1:0]        take_kind_o,
  input logic [LVL_W-1:0]  take_level_o,
  input logic [VEC_W-1:0]  vec_num_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [LVL_W-1:0]  ilm_o,
  input logic [ADDR_W-1:0] tbr_o
);
  logic mask_take;
  assign mask_take = take_o && (take_kind_o == KIND_MASK);

  assert_gate_below_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_take |-> (take_level_o < $past(ilm_o)));

  assert_level_off_never_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_take |-> (take_level_o != LVL_OFF));

  assert_ilm_loaded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_take |-> (ilm_o == take_level_o));

  assert_vec_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && (take_kind_o <= KIND_EXC)) |->
      (vec_addr_o == (($past(tbr_o) + 32'h3FC - {22'd0, vec_num_o, 2'b00}) & 32'hFFFF_FFFC)));

  assert_exempt_keeps_ilm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && (take_kind_o != KIND_MASK) && !$past(ilm_we_i)) |-> (ilm_o == $past(ilm_o)));

  assert_fixed_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && (take_kind_o == KIND_MODE)) |-> (vec_addr_o == MODE_ADDR));

  assert_fixed_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && (take_kind_o == KIND_RSTV)) |-> (vec_addr_o == RSTV_ADDR));

  assert_ilm_clamp_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ilm_we_i) && ($past(ilm_o) >= LVL_USER) && ($past(ilm_wdata_i) < LVL_USER) && !mask_take)
      |-> (ilm_o == $past(ilm_o)));
endmodule

bind irq_gate_top irq_gate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ilm_we_i     (ilm_we_i),
  .ilm_wdata_i  (ilm_wdata_i),
  .take_o       (take_o),
  .take_kind_o  (take_kind_o),
  .take_level_o (take_level_o),
  .vec_num_o    (vec_num_o),
  .vec_addr_o   (vec_addr_o),
  .ilm_o        (ilm_o),
  .tbr_o        (tbr_o)
);

// File: tb/irq_gate_top_tb.sv
module irq_gate_top_tb;
  localparam int N = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_valid_i = '0;
  logic [N*5-1:0] src_level_i = '0;
  logic [N*8-1:0] src_vec_i = '0;
  logic          exc_valid_i = 1'b0;
  logic [7:0]    exc_vec_i = '0;
  logic          mode_req_i = 1'b0;
  logic          rstv_req_i = 1'b0;
  logic          ilm_we_i = 1'b0;
  logic [4:0]    ilm_wdata_i = '0;
  logic          tbr_we_i = 1'b0;
  logic [31:0]   tbr_wdata_i = '0;
  logic          take_o;
  logic [1:0]    take_kind_o;
  logic [4:0]    take_level_o;
  logic [7:0]    vec_num_o;
  logic [31:0]   vec_addr_o;
  logic [4:0]    ilm_o;
  logic [31:0]   tbr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_gate_top #(.N_SRC(N)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_valid_i = '0; exc_valid_i = 1'b0; mode_req_i = 1'b0; rstv_req_i = 1'b0;
    ilm_we_i = 1'b0; tbr_we_i = 1'b0;
  endtask

  task automatic set_src(input int i, input logic [4:0] lvl, input logic [7:0] vec);
    src_valid_i[i] = 1'b1;
    src_level_i[i*5 +: 5] = lvl;
    src_vec_i[i*8 +: 8] = vec;
  endtask

  // drive at negedge, outputs land after the next posedge, sample at following negedge
  task automatic step();
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] vaddr(input logic [31:0] tbr, input logic [7:0] v);
    return (tbr + 32'h3FC - 32'(v) * 4) & 32'hFFFF_FFFC;
  endfunction

  task automatic wr_ilm(input logic [4:0] v);
    idle(); ilm_we_i = 1'b1; ilm_wdata_i = v; step(); idle();
  endtask

  task automatic t_reset();
    chk("R1 ilm", 32'(ilm_o), 32'd15);
    chk("R1 tbr", tbr_o, 32'h000F_FC00);
    chk("R1 take", 32'(take_o), 32'd0);
  endtask

  task automatic t_ilm_write();
    wr_ilm(5'd31);
    chk("R10 ilm write from 15", 32'(ilm_o), 32'd31);
    wr_ilm(5'd10);
    chk("R9 blocked write", 32'(ilm_o), 32'd31);
    wr_ilm(5'd16);
    chk("R10 write 16", 32'(ilm_o), 32'd16);
    wr_ilm(5'd15);
    chk("R9 blocked at 16", 32'(ilm_o), 32'd16);
    wr_ilm(5'd31);
  endtask

  task automatic t_mask();
    idle(); set_src(0, 5'd20, 8'd40); step();
    chk("R5 take", 32'(take_o), 32'd1);
    chk("R7 kind maskable", 32'(take_kind_o), 32'd0);
    chk("R5 vec", 32'(vec_num_o), 32'd40);
    chk("R5 level", 32'(take_level_o), 32'd20);
    chk("R6 addr", vec_addr_o, 32'h000F_FF5C);
    chk("R5 ilm loaded", 32'(ilm_o), 32'd20);
    step();
    chk("R2 equal level not taken", 32'(take_o), 32'd0);
    chk("R2 ilm kept", 32'(ilm_o), 32'd20);
    idle(); set_src(1, 5'd19, 8'd50); step(); idle();
    chk("R2 nested take", 32'(take_o), 32'd1);
    chk("R5 nested ilm", 32'(ilm_o), 32'd19);
    step();
    chk("R5 strobe one cycle", 32'(take_o), 32'd0);
  endtask

  task automatic t_off_level();
    wr_ilm(5'd31);
    chk("R10 raise ilm", 32'(ilm_o), 32'd31);
    idle(); set_src(2, 5'd31, 8'd3); step(); idle();
    chk("R3 level 31 no take", 32'(take_o), 32'd0);
    chk("R3 ilm unchanged", 32'(ilm_o), 32'd31);
  endtask

  task automatic t_arb();
    idle();
    set_src(0, 5'd22, 8'd5);
    set_src(1, 5'd18, 8'd9);
    set_src(2, 5'd18, 8'd7);
    set_src(3, 5'd25, 8'd1);
    step(); idle();
    chk("R4 take", 32'(take_o), 32'd1);
    chk("R4 winner vec", 32'(vec_num_o), 32'd7);
    chk("R4 winner level", 32'(take_level_o), 32'd18);
  endtask

  task automatic t_exempt();
    idle(); set_src(0, 5'd20, 8'd60); exc_valid_i = 1'b1; exc_vec_i = 8'd9; step(); idle();
    chk("R7 exempt take", 32'(take_o), 32'd1);
    chk("R7 kind exempt", 32'(take_kind_o), 32'd1);
    chk("R7 vec", 32'(vec_num_o), 32'd9);
    chk("R6 exempt addr", vec_addr_o, vaddr(32'h000F_FC00, 8'd9));
    chk("R7 ilm unchanged", 32'(ilm_o), 32'd18);
    wr_ilm(5'd16);
    idle(); exc_valid_i = 1'b1; exc_vec_i = 8'd12; step(); idle();
    chk("R7 exempt at ilm 16", 32'(take_kind_o), 32'd1);
    chk("R7 ilm stays 16", 32'(ilm_o), 32'd16);
  endtask

  task automatic t_tbr();
    idle(); tbr_we_i = 1'b1; tbr_wdata_i = 32'h0002_0003; step(); idle();
    chk("R11 tbr", tbr_o, 32'h0002_0003);
    exc_valid_i = 1'b1; exc_vec_i = 8'd3; step(); idle();
    chk("R6 low bits forced", vec_addr_o, 32'h0002_03F0);
    exc_valid_i = 1'b1; exc_vec_i = 8'd255; step(); idle();
    chk("R11 bottom entry", vec_addr_o, 32'h0002_0000);
  endtask

  task automatic t_fixed();
    idle(); mode_req_i = 1'b1; exc_valid_i = 1'b1; exc_vec_i = 8'd4; step(); idle();
    chk("R8 mode kind", 32'(take_kind_o), 32'd2);
    chk("R8 mode addr", vec_addr_o, 32'h000F_FFF8);
    chk("R8 mode vec", 32'(vec_num_o), 32'd1);
    rstv_req_i = 1'b1; mode_req_i = 1'b1; step(); idle();
    chk("R8 reset kind", 32'(take_kind_o), 32'd3);
    chk("R8 reset addr", vec_addr_o, 32'h000F_FFFC);
    chk("R8 reset vec", 32'(vec_num_o), 32'd0);
  endtask

  task automatic t_acc_vs_write();
    wr_ilm(5'd31);
    idle(); set_src(1, 5'd20, 8'd20); ilm_we_i = 1'b1; ilm_wdata_i = 5'd25; step(); idle();
    chk("R10 accept beats write", 32'(ilm_o), 32'd20);
    chk("R6 addr after tbr move", vec_addr_o, vaddr(32'h0002_0003, 8'd20));
    wr_ilm(5'd17);
    idle(); set_src(3, 5'd17, 8'd2); step(); idle();
    chk("R2 masked at equal", 32'(take_o), 32'd0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_ilm_write();
    t_mask();
    t_off_level();
    t_arb();
    t_exempt();
    t_tbr();
    t_fixed();
    t_acc_vs_write();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule